// File: doc/BRIEF.md
# Power-Down Mode Controller

This block manages the sleep depth of a processor core. Software writes a six-bit sleep code into the upper field of a 16-bit control word. A valid code puts the chip into one of three depths. The light depth gates only the CPU clock and keeps the DMA transfer clock running. The halt depth stops the PLL output. The stop depth also shuts off the PLL reference input. The sleep code also selects what wakes the chip: an interrupt allowed by the mask, any interrupt at all, or only a device reset.

Analog PLL behaviour, clock gating cells and pad freezing are represented by enable outputs. The lower ten bits of the control word are plain storage. They are kept through every depth, to model retained register contents. The two deep depths are refused while the PLL is bypassed, because the external clock would keep the chip running anyway. On a device reset, a wake from the halt depth releases clocks after a fixed settle period. A wake from the stop depth waits out a programmable relock count first.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After power-on reset, the status reads RUN (0), the CPU, DMA, PLL-output and PLL-reference enables are 1, `io_hold` is 0 and `rd_data` is 0.
- R2: A write in RUN with code 6'b001001 in bits 15:10 enters the light depth (status 1) at the next clock. `cpu_clk_en` goes 0, while `dma_clk_en` and both PLL enables stay 1, and bits 15:10 read back the code.
- R3: In the light depth entered with 6'b001001, only a nonzero `irq & irq_mask` returns the block to RUN, at the next clock. Interrupts outside the mask change nothing.
- R4: Code 6'b010001 also enters the light depth, and then any nonzero `irq` returns it to RUN at the next clock, whatever the mask.
- R5: Code 6'b011010 with `pll_en`=1 enters the halt depth (status 2). In it, `cpu_clk_en`, `dma_clk_en` and `pll_out_en` are 0, `pll_ref_en` is 1 and `io_hold` is 1. Interrupts have no effect. A `dev_rst` pulse moves it to the settle state (status 5) for exactly SETTLE_CYC (16) cycles, then to RUN.
- R6: Code 6'b011100 with `pll_en`=1 enters the stop depth (status 3), which also drives `pll_ref_en` to 0. A `dev_rst` pulse moves it to relock (status 4) with `pll_ref_en`=1 and `pll_out_en`=0 for `relock_cycles` cycles, or RELOCK_DEF (4096) cycles when `relock_cycles` is 0, then to RUN.
- R7: Any code other than 0 and the four valid codes leaves the status at RUN, and bits 15:10 read 0.
- R8: While `pll_en`=0, the halt and stop codes are refused and the status stays RUN.
- R9: Bits 9:0 are stored on every write accepted in RUN. They are kept unchanged through every depth and wake. Bits 15:10 read 0 again once RUN is reached.
- R10: `mode_status` encodes RUN=0, light=1, halt=2, stop=3, relock=4, settle=5. `io_hold` is 1 exactly in halt, stop, relock and settle.
- R11: Writes made outside RUN are ignored, and `dev_rst` in RUN changes nothing but the sleep code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst | input | 1 | Synchronous device reset, the wake source for the deep depths |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: sleep code in 15:10, storage in 9:0 |
| rd_data | output | 16 | Control word read-back |
| pll_en | input | 1 | 1 = PLL in use, 0 = PLL bypassed |
| irq | input | 8 | Interrupt lines |
| irq_mask | input | 8 | Interrupt enable mask |
| relock_cycles | input | 16 | Relock wait length, 0 selects RELOCK_DEF |
| cpu_clk_en | output | 1 | CPU core clock enable |
| dma_clk_en | output | 1 | DMA transfer path clock enable |
| pll_out_en | output | 1 | PLL output clock enable |
| pll_ref_en | output | 1 | PLL reference input enable |
| io_hold | output | 1 | Freeze outputs at their last values |
| mode_status | output | 3 | Current power state |

## Verification
Each light mode is tried with an interrupt outside the mask and then with one inside it. This shows whether the wake source follows the masked code or the any-interrupt code. The deep codes are written once with the PLL bypassed and once with it enabled, which separates refusal from entry. Interrupt storms and writes during the deep depths show that only `dev_rst` leaves them. The settle and relock periods are measured at their last cycle and the cycle after, with both an explicit and the default relock count. Reserved codes show that they neither change state nor latch into the read-back.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_LIGHT  = 3'd1,
    PM_HALT   = 3'd2,
    PM_STOP   = 3'd3,
    PM_RELOCK = 3'd4,
    PM_SETTLE = 3'd5
  } pm_state_t;

  localparam logic [5:0] CODE_LIGHT_MASKED = 6'b001001;
  localparam logic [5:0] CODE_LIGHT_ANY    = 6'b010001;
  localparam logic [5:0] CODE_HALT         = 6'b011010;
  localparam logic [5:0] CODE_STOP         = 6'b011100;

  // Down-counter load for a wait of n cycles, n == 0 picks the default.
  function automatic int unsigned wait_load(input int unsigned n, input int unsigned dflt);
    int unsigned eff;
    eff = (n == 0) ? dflt : n;
    return (eff == 0) ? 0 : eff - 1;
  endfunction
endpackage

// File: rtl/pd_decode.sv
module pd_decode
  import pd_pkg::*;
(
  input  logic [5:0] code,
  input  logic       pll_en,
  output logic       go_light,
  output logic       light_any,
  output logic       go_halt,
  output logic       go_stop,
  output logic       reserved_hit
);
  logic is_masked, is_any, is_halt, is_stop;

  always_comb begin
    is_masked    = (code == CODE_LIGHT_MASKED);
    is_any       = (code == CODE_LIGHT_ANY);
    is_halt      = (code == CODE_HALT);
    is_stop      = (code == CODE_STOP);
    go_light     = is_masked | is_any;
    light_any    = is_any;
    go_halt      = is_halt & pll_en;
    go_stop      = is_stop & pll_en;
    reserved_hit = (code != 6'd0) & ~(is_masked | is_any | is_halt | is_stop);
  end
endmodule

// File: rtl/pd_wake.sv
module pd_wake #(
  parameter int IRQ_N = 8
) (
  input  logic [IRQ_N-1:0] irq,
  input  logic [IRQ_N-1:0] irq_mask,
  input  logic             any_mode,
  output logic             wake
);
  logic [IRQ_N-1:0] eligible;

  genvar i;
  generate
    for (i = 0; i < IRQ_N; i++) begin : g_line
      assign eligible[i] = irq[i] & (any_mode | irq_mask[i]);
    end
  endgenerate

  assign wake = |eligible;
endmodule

// File: rtl/pd_timer.sv
module pd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (run && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expire = run && (cnt == '0);

  AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!por_n)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pd_pkg::*;
#(
  parameter int IRQ_N      = 8,
  parameter int CNT_W      = 16,
  parameter int RELOCK_DEF = 4096,
  parameter int SETTLE_CYC = 16,
  parameter int REG_W      = 16,
  parameter int CODE_W     = 6
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              dev_rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              pll_en,
  input  logic [IRQ_N-1:0]  irq,
  input  logic [IRQ_N-1:0]  irq_mask,
  input  logic [CNT_W-1:0]  relock_cycles,
  output logic              cpu_clk_en,
  output logic              dma_clk_en,
  output logic              pll_out_en,
  output logic              pll_ref_en,
  output logic              io_hold,
  output logic [2:0]        mode_status
);
  localparam int SCR_W = REG_W - CODE_W;

  pm_state_t         st;
  logic [CODE_W-1:0] code_q;
  logic [SCR_W-1:0]  scr_q;
  logic              any_q;

  logic go_light, light_any, go_halt, go_stop, reserved_hit;
  logic wake, t_load, t_run, t_expire;
  logic [CNT_W-1:0] t_val;
  logic [CODE_W-1:0] wcode;

  assign wcode = wr_data[REG_W-1:SCR_W];

  pd_decode u_dec (
    .code(wcode), .pll_en(pll_en), .go_light(go_light), .light_any(light_any),
    .go_halt(go_halt), .go_stop(go_stop), .reserved_hit(reserved_hit)
  );

  pd_wake #(.IRQ_N(IRQ_N)) u_wake (
    .irq(irq), .irq_mask(irq_mask), .any_mode(any_q), .wake(wake)
  );

  assign t_load = dev_rst && (st == PM_HALT || st == PM_STOP);
  assign t_run  = (st == PM_RELOCK) || (st == PM_SETTLE);
  assign t_val  = (st == PM_STOP)
                ? CNT_W'(wait_load(int'(relock_cycles), RELOCK_DEF))
                : CNT_W'(wait_load(SETTLE_CYC, SETTLE_CYC));

  pd_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .por_n(por_n), .load(t_load), .load_val(t_val),
    .run(t_run), .expire(t_expire)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st     <= PM_RUN;
      code_q <= '0;
      scr_q  <= '0;
      any_q  <= 1'b0;
    end else begin
      unique case (st)
        PM_RUN: begin
          if (dev_rst) begin
            code_q <= '0;
          end else if (wr_en) begin
            scr_q <= wr_data[SCR_W-1:0];
            if (go_light) begin
              st     <= PM_LIGHT;
              code_q <= wcode;
              any_q  <= light_any;
            end else if (go_halt) begin
              st     <= PM_HALT;
              code_q <= wcode;
            end else if (go_stop) begin
              st     <= PM_STOP;
              code_q <= wcode;
            end
          end
        end
        PM_LIGHT: if (dev_rst || wake) begin
          st     <= PM_RUN;
          code_q <= '0;
        end
        PM_HALT: if (dev_rst) st <= PM_SETTLE;
        PM_STOP: if (dev_rst) st <= PM_RELOCK;
        PM_RELOCK, PM_SETTLE: if (t_expire) begin
          st     <= PM_RUN;
          code_q <= '0;
        end
        default: st <= PM_RUN;
      endcase
    end
  end

  assign cpu_clk_en  = (st == PM_RUN);
  assign dma_clk_en  = (st == PM_RUN) || (st == PM_LIGHT);
  assign pll_out_en  = (st == PM_RUN) || (st == PM_LIGHT) || (st == PM_SETTLE);
  assign pll_ref_en  = (st != PM_STOP);
  assign io_hold     = (st == PM_HALT) || (st == PM_STOP) || t_run;
  assign mode_status = st;
  assign rd_data     = {code_q, scr_q};

  AST_MASKED_WAKE_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    (st == PM_LIGHT && !any_q && (irq & irq_mask) == '0 && !dev_rst) |=> (st == PM_LIGHT)); // R3
  AST_ANY_IRQ_WAKES: assert property (@(posedge clk) disable iff (!por_n)
    (st == PM_LIGHT && any_q && |irq) |=> (mode_status == 3'd0 && cpu_clk_en)); // R4
  AST_DEEP_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    ((st == PM_HALT || st == PM_STOP) && !dev_rst) |=> ($stable(mode_status) && $stable(rd_data))); // R5
  AST_STOP_TO_RELOCK: assert property (@(posedge clk) disable iff (!por_n)
    (st == PM_STOP && dev_rst) |=> (mode_status == 3'd4 && pll_ref_en && !pll_out_en)); // R6
  AST_BYPASS_REFUSE: assert property (@(posedge clk) disable iff (!por_n)
    (st == PM_RUN && wr_en && !dev_rst && !pll_en) |=> (mode_status == 3'd0 || mode_status == 3'd1)); // R8
  AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!por_n)
    (st == PM_RUN && wr_en && !dev_rst && reserved_hit) |=> (mode_status == 3'd0 && rd_data[REG_W-1:SCR_W] == '0)); // R7
  AST_SCRATCH_KEPT: assert property (@(posedge clk) disable iff (!por_n)
    (st != PM_RUN) |=> $stable(rd_data[SCR_W-1:0])); // R9
endmodule

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        dev_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        pll_en = 1'b1;
  logic [7:0]  irq = '0;
  logic [7:0]  irq_mask = '0;
  logic [15:0] relock_cycles = 16'd20;
  logic cpu_clk_en, dma_clk_en, pll_out_en, pll_ref_en, io_hold;
  logic [2:0]  mode_status;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwrdn_ctrl u_dut (
    .clk(clk), .por_n(por_n), .dev_rst(dev_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pll_en(pll_en), .irq(irq), .irq_mask(irq_mask),
    .relock_cycles(relock_cycles), .cpu_clk_en(cpu_clk_en), .dma_clk_en(dma_clk_en),
    .pll_out_en(pll_out_en), .pll_ref_en(pll_ref_en), .io_hold(io_hold),
    .mode_status(mode_status)
  );

  // Behavioural reference: state number, remaining wait, code, storage, wake kind
  int m_st = 0, m_left = 0, m_code = 0, m_scr = 0;
  bit m_any = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!por_n) begin
      m_st = 0; m_code = 0; m_scr = 0; m_any = 0; m_left = 0;
    end else begin
      case (m_st)
        0: if (dev_rst) m_code = 0;
           else if (wr_en) begin
             m_scr = wr_data[9:0];
             case (wr_data[15:10])
               6'b001001: begin m_st = 1; m_code = 9;  m_any = 0; end
               6'b010001: begin m_st = 1; m_code = 17; m_any = 1; end
               6'b011010: if (pll_en) begin m_st = 2; m_code = 26; end
               6'b011100: if (pll_en) begin m_st = 3; m_code = 28; end
               default: ;
             endcase
           end
        1: if (dev_rst || (m_any ? (irq != 0) : ((irq & irq_mask) != 0))) begin
             m_st = 0; m_code = 0;
           end
        2: if (dev_rst) begin m_st = 5; m_left = 16; end
        3: if (dev_rst) begin m_st = 4; m_left = (relock_cycles == 0) ? 4096 : relock_cycles; end
        default: begin
          m_left--;
          if (m_left == 0) begin m_st = 0; m_code = 0; end
        end
      endcase
    end
    #2;
    if (!done) begin
      check(mode_status == m_st, "R10 mode_status", mode_status, m_st);
      check(cpu_clk_en == (m_st == 0), "R2 cpu_clk_en", cpu_clk_en, m_st == 0);
      check(dma_clk_en == (m_st <= 1), "R2 dma_clk_en", dma_clk_en, m_st <= 1);
      check(pll_out_en == (m_st <= 1 || m_st == 5), "R5 pll_out_en", pll_out_en, m_st <= 1 || m_st == 5);
      check(pll_ref_en == (m_st != 3), "R6 pll_ref_en", pll_ref_en, m_st != 3);
      check(io_hold == (m_st >= 2), "R10 io_hold", io_hold, m_st >= 2);
      check(rd_data == 16'((m_code << 10) | m_scr), "R9 rd_data", rd_data, (m_code << 10) | m_scr);
    end
  end

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] code, input logic [9:0] scr);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {code, scr};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_rst();
    @(negedge clk);
    dev_rst = 1'b1;
    @(negedge clk);
    dev_rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(2);
    check(mode_status == 0 && cpu_clk_en && dma_clk_en && pll_out_en && pll_ref_en, "R1 reset enables", mode_status, 0);
    check(rd_data == 0 && !io_hold, "R1 reset read-back", rd_data, 0);
    por_n = 1'b1;
    cyc(1);

    wr(6'b000001, 10'h055);
    check(mode_status == 0, "R7 reserved state", mode_status, 0);
    check(rd_data == 16'h0055, "R7 reserved read-back", rd_data, 16'h0055);
    wr(6'b111111, 10'h055);
    check(mode_status == 0, "R7 reserved 111111", mode_status, 0);

    wr(6'b001001, 10'h03A);
    check(mode_status == 1 && !cpu_clk_en && dma_clk_en && pll_out_en, "R2 light entry", mode_status, 1);
    check(rd_data[15:10] == 6'b001001, "R2 code read-back", rd_data[15:10], 9);
    irq_mask = 8'h02; irq = 8'h01;
    cyc(3);
    check(mode_status == 1, "R3 masked irq ignored", mode_status, 1);
    irq = 8'h02;
    cyc(1);
    irq = 8'h00;
    check(mode_status == 0 && rd_data[15:10] == 0, "R3 enabled irq wakes", mode_status, 0);

    irq_mask = 8'h00;
    wr(6'b010001, 10'h111);
    check(mode_status == 1, "R4 any-wake entry", mode_status, 1);
    wr(6'b011010, 10'h222);
    check(rd_data == {6'b010001, 10'h111}, "R11 write in light ignored", rd_data, {6'b010001, 10'h111});
    irq = 8'h80;
    cyc(1);
    irq = 8'h00;
    check(mode_status == 0, "R4 unmasked irq wakes", mode_status, 0);

    pll_en = 1'b0;
    wr(6'b011010, 10'h001);
    check(mode_status == 0, "R8 halt refused", mode_status, 0);
    wr(6'b011100, 10'h002);
    check(mode_status == 0 && rd_data[15:10] == 0, "R8 stop refused", mode_status, 0);
    pll_en = 1'b1;

    wr(6'b011010, 10'h2C5);
    check(mode_status == 2 && !pll_out_en && pll_ref_en && io_hold && !dma_clk_en, "R5 halt entry", mode_status, 2);
    irq = 8'hFF; irq_mask = 8'hFF;
    cyc(4);
    check(mode_status == 2, "R5 irq ignored in halt", mode_status, 2);
    irq = 8'h00;
    wr(6'b001001, 10'h000);
    check(rd_data == {6'b011010, 10'h2C5}, "R11 write in halt ignored", rd_data, {6'b011010, 10'h2C5});
    pulse_rst();
    check(mode_status == 5 && pll_out_en && !cpu_clk_en, "R5 settle entry", mode_status, 5);
    cyc(15);
    check(mode_status == 5, "R5 settle last cycle", mode_status, 5);
    cyc(1);
    check(mode_status == 0, "R5 settle done", mode_status, 0);
    check(rd_data == 16'h02C5, "R9 storage kept after halt", rd_data, 16'h02C5);

    relock_cycles = 16'd20;
    wr(6'b011100, 10'h155);
    check(mode_status == 3 && !pll_ref_en && !pll_out_en, "R6 stop entry", mode_status, 3);
    pulse_rst();
    check(mode_status == 4 && pll_ref_en && !pll_out_en && io_hold, "R6 relock entry", mode_status, 4);
    cyc(19);
    check(mode_status == 4, "R6 relock last cycle", mode_status, 4);
    cyc(1);
    check(mode_status == 0 && rd_data == 16'h0155, "R6 relock done", mode_status, 0);

    relock_cycles = 16'd0;
    wr(6'b011100, 10'h0AA);
    pulse_rst();
    cyc(4095);
    check(mode_status == 4, "R6 default relock last cycle", mode_status, 4);
    cyc(1);
    check(mode_status == 0, "R6 default relock done", mode_status, 0);

    pulse_rst();
    check(mode_status == 0 && rd_data == 16'h00AA, "R11 dev_rst in RUN", rd_data, 16'h00AA);

    wr(6'b001001, 10'h3FF);
    pulse_rst();
    check(mode_status == 0 && rd_data == 16'h03FF, "R3 dev_rst wakes light", mode_status, 0);

    cyc(3);
    finish_run();
  end
endmodule